// File: doc/BRIEF.md
# Segment Base and Limit Translator

This block turns a segmented logical address, given as a segment index and an offset inside that segment, into a physical address. A small table holds one base and one limit for each segment. Software fills the table through a write port. Each request is first checked against the limit of the selected segment. If the offset is strictly below the limit, the block returns the base plus the offset. If it is not, the block raises a protection fault and returns no address.

The response is registered. It appears on the cycle after the request, together with a response-valid strobe. The table resets with every limit at zero, so a segment that has never been programmed rejects every offset. A table write takes effect from the cycle after it is issued. A request made in the same cycle as a write sees the entry as it stood before that write.

Top module: `seg_xlate`

## Requirements
- R1: `rsp_valid_o` is high in the cycle that follows a cycle with `req_valid_i` high, and low in every other cycle.
- R2: When the offset is strictly less than the selected segment's limit, `rsp_fault_o` is 0 and `rsp_paddr_o` equals base plus offset, computed at 17 bits with no wraparound (base 0xFFFF plus offset 0xFFFE gives 0x1FFFD).
- R3: When the offset is greater than or equal to the selected segment's limit, `rsp_fault_o` is 1 and `rsp_paddr_o` is 0.
- R4: After reset every entry has limit 0, so every request faults until its entry is written with a nonzero limit.
- R5: A write with `cfg_we_i` high updates entry `cfg_idx_i` at the clock edge. A request issued in the same cycle to the same entry uses the old contents, and requests in later cycles use the new contents.
- R6: A write to one entry leaves the base and limit of every other entry unchanged.
- R7: While `rsp_valid_o` is low, `rsp_fault_o` and `rsp_paddr_o` are both 0.
- R8: At the bounds of a segment, offset limit-1 translates and offset equal to limit faults.
- R9: `req_seg_i` selects which of the 4 entries (index 0 to 3) supplies the base and limit for a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_idx_i | input | 2 | Entry to write |
| cfg_base_i | input | 16 | Base to store |
| cfg_limit_i | input | 16 | Limit to store (0 marks the entry as empty) |
| req_valid_i | input | 1 | Translation request strobe |
| req_seg_i | input | 2 | Segment index of the request |
| req_off_i | input | 16 | Offset within the segment |
| rsp_valid_o | output | 1 | Response strobe, one cycle after a request |
| rsp_fault_o | output | 1 | Protection fault: the offset is not below the limit |
| rsp_paddr_o | output | 17 | Translated physical address, 0 on a fault |

## Verification
The assertions check the following on every cycle:
- the one-cycle response timing;
- the quiet outputs when no response is due;
- the zeroed address on a fault;
- a successful address is never below its offset;
- the fault on any entry that holds no nonzero limit.

Only the bench scenarios can show the following, because they need known table contents:
- the exact base-plus-offset sums;
- the limit-1 and limit edges of each segment;
- the carry out of a 16-bit sum;
- the old contents seen when a write and a request coincide;
- the isolation of one entry from writes to another.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int SEG_BASE_W = 16;
  localparam int SEG_LIM_W  = 16;
  localparam int SEG_OFF_W  = 16;
  localparam int SEG_ADDR_W = ((SEG_BASE_W > SEG_OFF_W) ? SEG_BASE_W : SEG_OFF_W) + 1;

  typedef struct packed {
    logic [SEG_BASE_W-1:0] base;
    logic [SEG_LIM_W-1:0]  limit;
  } seg_entry_t;
endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 4,
  localparam int IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  seg_entry_t       wr_entry_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output seg_entry_t       rd_entry_o
);
  seg_entry_t entry_q [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   entry_q[g] <= '0;
      else if (we_i && (wr_idx_i == IDX_W'(g)))      entry_q[g] <= wr_entry_i;
    end
  end

  // read sees pre-write contents in the write cycle
  assign rd_entry_o = entry_q[rd_idx_i];
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
(
  input  seg_entry_t              entry_i,
  input  logic [SEG_OFF_W-1:0]    off_i,
  output logic                    fault_o,
  output logic [SEG_ADDR_W-1:0]   paddr_o
);
  always_comb begin
    fault_o = !(off_i < entry_i.limit);
    paddr_o = fault_o ? '0 : (SEG_ADDR_W'(entry_i.base) + SEG_ADDR_W'(off_i));
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 4,
  localparam int IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [IDX_W-1:0]      cfg_idx_i,
  input  logic [SEG_BASE_W-1:0] cfg_base_i,
  input  logic [SEG_LIM_W-1:0]  cfg_limit_i,
  input  logic                  req_valid_i,
  input  logic [IDX_W-1:0]      req_seg_i,
  input  logic [SEG_OFF_W-1:0]  req_off_i,
  output logic                  rsp_valid_o,
  output logic                  rsp_fault_o,
  output logic [SEG_ADDR_W-1:0] rsp_paddr_o
);
  seg_entry_t             wr_entry, rd_entry;
  logic                   chk_fault;
  logic [SEG_ADDR_W-1:0]  chk_paddr;

  assign wr_entry = '{base: cfg_base_i, limit: cfg_limit_i};

  seg_table #(.NUM_SEG(NUM_SEG)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .wr_idx_i   (cfg_idx_i),
    .wr_entry_i (wr_entry),
    .rd_idx_i   (req_seg_i),
    .rd_entry_o (rd_entry)
  );

  seg_check u_check (
    .entry_i (rd_entry),
    .off_i   (req_off_i),
    .fault_o (chk_fault),
    .paddr_o (chk_paddr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_fault_o <= req_valid_i & chk_fault;
      rsp_paddr_o <= req_valid_i ? chk_paddr : '0;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 4,
  localparam int IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cfg_we_i,
  input logic [IDX_W-1:0]      cfg_idx_i,
  input logic [SEG_LIM_W-1:0]  cfg_limit_i,
  input logic                  req_valid_i,
  input logic [IDX_W-1:0]      req_seg_i,
  input logic [SEG_OFF_W-1:0]  req_off_i,
  input logic                  rsp_valid_o,
  input logic                  rsp_fault_o,
  input logic [SEG_ADDR_W-1:0] rsp_paddr_o
);
  // entries known to hold a nonzero limit, tracked from the write port
  logic [NUM_SEG-1:0] live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       live_q <= '0;
    else if (cfg_we_i) live_q[cfg_idx_i] <= (cfg_limit_i != '0);
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_fault_o && rsp_paddr_o == '0)); // R7
  AST_FAULT_NO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (rsp_paddr_o == '0)); // R3
  AST_ADDR_COVERS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i ##1 (rsp_valid_o && !rsp_fault_o)) |-> (rsp_paddr_o >= SEG_ADDR_W'($past(req_off_i)))); // R2
  AST_BLANK_FAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !live_q[req_seg_i]) |=> rsp_fault_o); // R4
endmodule

bind seg_xlate seg_xlate_chk #(.NUM_SEG(NUM_SEG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_idx_i   (cfg_idx_i),
  .cfg_limit_i (cfg_limit_i),
  .req_valid_i (req_valid_i),
  .req_seg_i   (req_seg_i),
  .req_off_i   (req_off_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_fault_o (rsp_fault_o),
  .rsp_paddr_o (rsp_paddr_o)
);

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [15:0] cfg_base = '0;
  logic [15:0] cfg_limit = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_seg = '0;
  logic [15:0] req_off = '0;
  logic        rsp_valid, rsp_fault;
  logic [16:0] rsp_paddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  seg_xlate u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_base_i(cfg_base), .cfg_limit_i(cfg_limit),
    .req_valid_i(req_valid), .req_seg_i(req_seg), .req_off_i(req_off),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_paddr_o(rsp_paddr)
  );

  // {seg, offset, expected fault, expected address}
  localparam int NV = 10;
  localparam logic [35:0] VEC [NV] = '{
    {2'd1, 16'd100,  1'b0, 17'h03064},
    {2'd1, 16'd5000, 1'b1, 17'h00000},
    {2'd0, 16'd0,    1'b0, 17'h01000},
    {2'd0, 16'd4095, 1'b0, 17'h01FFF},
    {2'd0, 16'd4096, 1'b1, 17'h00000},
    {2'd2, 16'd1023, 1'b0, 17'h053FF},
    {2'd2, 16'd1024, 1'b1, 17'h00000},
    {2'd3, 16'd0,    1'b1, 17'h00000},
    {2'd1, 16'd2047, 1'b0, 17'h037FF},
    {2'd1, 16'd2048, 1'b1, 17'h00000}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] idx, logic [15:0] base, logic [15:0] lim);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_base = base; cfg_limit = lim;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // issue at a negedge, sample at the next negedge (one register stage)
  task automatic req(logic [1:0] seg, logic [15:0] off, string tag, logic fault_e, logic [16:0] addr_e);
    @(negedge clk);
    req_valid = 1'b1; req_seg = seg; req_off = off;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " fault"}, 32'(rsp_fault), 32'(fault_e));
    chk({tag, " paddr"}, 32'(rsp_paddr), 32'(addr_e));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset valid", 32'(rsp_valid), 32'd0);
    chk("R7 reset paddr", 32'(rsp_paddr), 32'd0);
    rst_n = 1'b1;

    // R4: untouched table rejects everything
    req(2'd0, 16'd0, "R4 blank seg0", 1'b1, 17'h0);
    req(2'd2, 16'd5, "R4 blank seg2", 1'b1, 17'h0);
    @(negedge clk);
    chk("R1 strobe drops", 32'(rsp_valid), 32'd0);
    chk("R7 idle fault", 32'(rsp_fault), 32'd0);

    wr(2'd0, 16'h1000, 16'd4096);
    wr(2'd1, 16'h3000, 16'd2048);
    wr(2'd2, 16'h5000, 16'd1024);

    // R2 R3 R8 R9 vector walk
    for (int i = 0; i < NV; i++) begin
      req(VEC[i][35:34], VEC[i][33:18], $sformatf("R2/R3/R8/R9 vec%0d", i), VEC[i][17], VEC[i][16:0]);
    end

    // R2: carry out of 16 bits is kept
    wr(2'd3, 16'hFFFF, 16'hFFFF);
    req(2'd3, 16'hFFFE, "R2 carry", 1'b0, 17'h1FFFD);
    req(2'd3, 16'hFFFF, "R8 max limit", 1'b1, 17'h0);

    // R6: other entries unchanged after writing seg3
    req(2'd0, 16'd10, "R6 seg0 kept", 1'b0, 17'h0100A);
    req(2'd2, 16'd1023, "R6 seg2 kept", 1'b0, 17'h053FF);

    // R5: write and request in the same cycle see old contents
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd1; cfg_base = 16'h8000; cfg_limit = 16'd16;
    req_valid = 1'b1; req_seg = 2'd1; req_off = 16'd100;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R5 same-cycle old fault", 32'(rsp_fault), 32'd0);
    chk("R5 same-cycle old paddr", 32'(rsp_paddr), 32'h3064);
    req(2'd1, 16'd100, "R5 new limit", 1'b1, 17'h0);
    req(2'd1, 16'd15, "R5 new base", 1'b0, 17'h0800F);

    // R4: writing limit 0 empties an entry
    wr(2'd0, 16'h1000, 16'd0);
    req(2'd0, 16'd0, "R4 cleared", 1'b1, 17'h0);

    // R1: back-to-back requests give back-to-back responses
    @(negedge clk);
    req_valid = 1'b1; req_seg = 2'd2; req_off = 16'd1;
    @(negedge clk);
    chk("R1 b2b first", 32'(rsp_paddr), 32'h5001);
    req_off = 16'd2;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 b2b second valid", 32'(rsp_valid), 32'd1);
    chk("R1 b2b second", 32'(rsp_paddr), 32'h5002);
    @(negedge clk);
    chk("R7 idle after b2b", 32'(rsp_paddr), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule